// File: doc/BRIEF.md
# Bootstrap SRAM Copy Engine

This block keeps a small always-on memory that holds a bootstrap program, and copies a run of 32-bit words from it into a processor's instruction memory. A host programs a source byte offset inside the bootstrap memory, a destination byte address and a word count through a register interface. It then launches the copy either at once, through a self-clearing start bit, or automatically on every power-up event, through a separate arm bit. The copy drives a simple write port with a ready input. It moves one word per cycle while the destination accepts.

Four extra 32-bit registers hold image pointers and byte counts. The bootstrap program reads them later. They are plain storage and have no effect on the copy. Software polls the start bit or the done flag to learn when the copy has finished.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset the control word (offset 0x000) and the status word (offset 0x010) read 0, `busy` and `done` are low, and `dstWrEn` is low.
- R2: A host write to offsets 0x400..0x7FF stores the 32-bit data into the bootstrap memory word selected by address bits 9:2, and a read at the same offset returns it.
- R3: The source offset (0x004), destination address (0x008), word count (0x00C) and the four image registers (0x090, 0x094, 0x098, 0x09C, including bit 31 of 0x094) read back what was written, and writing the image registers starts no copy.
- R4: A control write with bit 31 set launches a copy in the next cycle. Control bit 31 reads 1 while the copy runs and 0 once it completes.
- R5: In each copy cycle `dstWrEn` is high with `dstAddr` at the current destination and `dstWrData` equal to the bootstrap word at the current source. When `dstReady` is high, both addresses advance by 4 bytes. When it is low, the write holds unchanged.
- R6: The source word index wraps from the last bootstrap word (byte offset 0x3FC) to the first.
- R7: A copy with word count 0 is busy for one cycle, makes no destination write, and sets done.
- R8: Status bit 0 (done) becomes 1 in the cycle the copy ends, and clears when the next copy launches.
- R9: A start write while a copy is running is ignored, and changes to the source, destination or count registers during a copy do not alter it.
- R10: Control bit 30 arms automatic copies and reads back as written. A one-cycle `powerUp` pulse while armed and idle launches a copy with the current register values. While not armed, the pulse is ignored.
- R11: A start write and a power-up pulse in the same idle cycle, with the arm bit set, launch exactly one copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Host register/memory write strobe |
| regAddr | input | 12 | Host byte address within the block |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for `regAddr` (combinational) |
| powerUp | input | 1 | One-cycle power-up event |
| dstReady | input | 1 | Destination memory accepts a write |
| dstWrEn | output | 1 | Destination write request |
| dstAddr | output | 32 | Destination byte address |
| dstWrData | output | 32 | Destination write data |
| busy | output | 1 | A copy is running |
| done | output | 1 | The last copy has completed |

## Verification
A host start write and an armed power-up pulse can land in the same idle cycle, and both ask the sequencer to launch. The bench drives the register write strobe and the pulse in one cycle with the arm bit set. It queues the expected destination writes of a single copy only. The scoreboard must drain that queue and see no extra write in the following cycles, and the block must go idle with done set.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] CTRL_OFS   = 12'h000;
  localparam logic [ADDR_W-1:0] SRC_OFS    = 12'h004;
  localparam logic [ADDR_W-1:0] DST_OFS    = 12'h008;
  localparam logic [ADDR_W-1:0] COUNT_OFS  = 12'h00C;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 12'h010;
  localparam logic [ADDR_W-1:0] INFO_BASE  = 12'h090;
  localparam logic [ADDR_W-1:0] MEM_BASE   = 12'h400;

  localparam int START_BIT = 31;
  localparam int ARM_BIT   = 30;

  typedef struct packed {
    logic load;
    logic write;
    logic step;
    logic finish;
  } seqStrobes_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_COPY = 1'b1
  } seqState_t;
endpackage

// File: rtl/boot_copy_ctrl.sv
module boot_copy_ctrl
  import boot_copy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        powerUp,
  input  logic        armed,
  input  logic        remZero,
  input  logic        remOne,
  input  logic        dstReady,
  output seqStrobes_t seq,
  output logic        busy
);
  seqState_t state;
  logic      launch;

  assign busy = (state == SEQ_COPY);

  always_comb begin
    seq    = '0;
    launch = (state == SEQ_IDLE) && (startReq || (powerUp && armed));
    seq.load = launch;
    if (state == SEQ_COPY) begin
      seq.write  = !remZero;
      seq.step   = seq.write && dstReady;
      seq.finish = remZero || (seq.step && remOne);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
    end else begin
      case (state)
        SEQ_IDLE: if (launch)     state <= SEQ_COPY;
        SEQ_COPY: if (seq.finish) state <= SEQ_IDLE;
        default:                  state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_copy_datapath.sv
module boot_copy_datapath
  import boot_copy_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  parameter int INFO_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  seqStrobes_t       seq,
  input  logic              busy,
  output logic              startReq,
  output logic              armed,
  output logic              remZero,
  output logic              remOne,
  output logic              dstWrEn,
  output logic [DATA_W-1:0] dstAddr,
  output logic [DATA_W-1:0] dstWrData,
  output logic              done
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int MEM_WORDS  = MEM_BYTES / WORD_BYTES;
  localparam int MEM_IDX_W  = $clog2(MEM_WORDS);
  localparam int LSB_W      = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] MEM_END = MEM_BASE + ADDR_W'(MEM_BYTES);

  logic [DATA_W-1:0]    bootMem [MEM_WORDS];
  logic [DATA_W-1:0]    srcReg, dstReg, cntReg;
  logic [DATA_W-1:0]    infoReg [INFO_REGS];
  logic [MEM_IDX_W-1:0] curSrcIdx;
  logic [DATA_W-1:0]    curDst, remaining;
  logic                 ctrlHit, memHit;
  logic [MEM_IDX_W-1:0] hostIdx;

  assign ctrlHit  = regWrEn && (regAddr == CTRL_OFS);
  assign startReq = ctrlHit && regWrData[START_BIT];
  assign memHit   = (regAddr >= MEM_BASE) && (regAddr < MEM_END);
  assign hostIdx  = regAddr[MEM_IDX_W+LSB_W-1:LSB_W];

  // Bootstrap store: no reset so it models retention across sleep
  always_ff @(posedge clk) begin
    if (regWrEn && memHit) bootMem[hostIdx] <= regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      srcReg <= '0;
      dstReg <= '0;
      cntReg <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        CTRL_OFS:  armed  <= regWrData[ARM_BIT];
        SRC_OFS:   srcReg <= regWrData;
        DST_OFS:   dstReg <= regWrData;
        COUNT_OFS: cntReg <= regWrData;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < INFO_REGS; g++) begin : g_info
    localparam logic [ADDR_W-1:0] MY_OFS = INFO_BASE + ADDR_W'(g * WORD_BYTES);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             infoReg[g] <= '0;
      else if (regWrEn && regAddr == MY_OFS) infoReg[g] <= regWrData;
    end
  end

  // Working copy state, captured at launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrcIdx <= '0;
      curDst    <= '0;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      if (seq.load) begin
        curSrcIdx <= srcReg[MEM_IDX_W+LSB_W-1:LSB_W];
        curDst    <= dstReg;
        remaining <= cntReg;
        done      <= 1'b0;
      end else if (seq.step) begin
        curSrcIdx <= curSrcIdx + 1'b1;
        curDst    <= curDst + DATA_W'(WORD_BYTES);
        remaining <= remaining - 1'b1;
      end
      if (seq.finish) done <= 1'b1;
    end
  end

  assign remZero   = (remaining == '0);
  assign remOne    = (remaining == DATA_W'(1));
  assign dstWrEn   = seq.write;
  assign dstAddr   = curDst;
  assign dstWrData = bootMem[curSrcIdx];

  always_comb begin
    regRdData = '0;
    if (memHit) begin
      regRdData = bootMem[hostIdx];
    end else begin
      case (regAddr)
        CTRL_OFS: begin
          regRdData[START_BIT] = busy;
          regRdData[ARM_BIT]   = armed;
        end
        SRC_OFS:    regRdData = srcReg;
        DST_OFS:    regRdData = dstReg;
        COUNT_OFS:  regRdData = cntReg;
        STATUS_OFS: regRdData[0] = done;
        default: begin
          for (int i = 0; i < INFO_REGS; i++) begin
            if (regAddr == INFO_BASE + ADDR_W'(i * WORD_BYTES)) regRdData = infoReg[i];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import boot_copy_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  parameter int INFO_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              powerUp,
  input  logic              dstReady,
  output logic              dstWrEn,
  output logic [DATA_W-1:0] dstAddr,
  output logic [DATA_W-1:0] dstWrData,
  output logic              busy,
  output logic              done
);
  seqStrobes_t seq;
  logic        startReq, armed, remZero, remOne;

  boot_copy_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .powerUp  (powerUp),
    .armed    (armed),
    .remZero  (remZero),
    .remOne   (remOne),
    .dstReady (dstReady),
    .seq      (seq),
    .busy     (busy)
  );

  boot_copy_datapath #(
    .DATA_W    (DATA_W),
    .MEM_BYTES (MEM_BYTES),
    .INFO_REGS (INFO_REGS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .seq       (seq),
    .busy      (busy),
    .startReq  (startReq),
    .armed     (armed),
    .remZero   (remZero),
    .remOne    (remOne),
    .dstWrEn   (dstWrEn),
    .dstAddr   (dstAddr),
    .dstWrData (dstWrData),
    .done      (done)
  );
endmodule

// File: rtl/boot_copy_checker.sv
module boot_copy_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              dstReady,
  input logic              dstWrEn,
  input logic [DATA_W-1:0] dstAddr,
  input logic              busy,
  input logic              done
);
  // R5
  write_in_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> busy);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dstWrEn && !dstReady) |=> (dstWrEn && $stable(dstAddr)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dstWrEn && dstReady) |=> (!dstWrEn || dstAddr == $past(dstAddr) + DATA_W'(4)));

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));
endmodule

bind boot_copy_engine boot_copy_checker #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dstReady (dstReady),
  .dstWrEn  (dstWrEn),
  .dstAddr  (dstAddr),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_boot_copy_engine.sv
module test_boot_copy_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        powerUp = 1'b0;
  logic        dstReady = 1'b1;
  logic        dstWrEn;
  logic [31:0] dstAddr, dstWrData;
  logic        busy, done;

  int errors = 0;
  int checks = 0;
  int writesSeen = 0;
  bit finished = 0;
  logic [63:0] expQ[$];
  logic [31:0] memModel [256];

  always #10 clk = ~clk;

  boot_copy_engine i_boot_copy_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .powerUp(powerUp),
    .dstReady(dstReady), .dstWrEn(dstWrEn), .dstAddr(dstAddr),
    .dstWrData(dstWrData), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && dstWrEn && dstReady) begin
      writesSeen++;
      if (expQ.size() == 0) begin
        check(0, "R5 unexpected destination write", {dstAddr, dstWrData}, 64'h0);
      end else begin
        logic [63:0] e;
        e = expQ.pop_front();
        check({dstAddr, dstWrData} == e, "R5/R6 destination write", {dstAddr, dstWrData}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic pushCopy(input logic [31:0] srcByte, input logic [31:0] dst, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      int idx;
      idx = (int'(srcByte[9:2]) + k) % 256;
      expQ.push_back({dst + 32'(4 * k), memModel[idx]});
    end
  endtask

  task automatic setupCopy(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    hostWrite(12'h004, s);
    hostWrite(12'h008, d);
    hostWrite(12'h00C, c);
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] r;
    int n = 0;
    hostRead(12'h000, r);
    while (r[31] && n < 2000) begin
      tick(1); n++; hostRead(12'h000, r);
    end
    check(!r[31], tag, {32'h0, r}, 64'h0);
  endtask

  task automatic pulsePowerUp();
    @(posedge clk); #1; powerUp = 1'b1;
    @(posedge clk); #1; powerUp = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int base;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    hostRead(12'h000, r); check(r == 0, "R1 control after reset", {32'h0, r}, 64'h0);
    hostRead(12'h010, r); check(r == 0, "R1 status after reset", {32'h0, r}, 64'h0);
    check(!busy && !done && !dstWrEn, "R1 outputs after reset", {61'h0, busy, done, dstWrEn}, 64'h0);

    // R2 fill bootstrap memory
    for (int i = 0; i < 256; i++) begin
      memModel[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
      hostWrite(12'h400 + 12'(4 * i), memModel[i]);
    end
    hostRead(12'h404, r); check(r == memModel[1], "R2 memory readback 0x404", {32'h0, r}, {32'h0, memModel[1]});
    hostRead(12'h7FC, r); check(r == memModel[255], "R2 memory readback 0x7FC", {32'h0, r}, {32'h0, memModel[255]});

    // R3 register storage, image registers do not start a copy
    hostWrite(12'h090, 32'h1111_2220);
    hostWrite(12'h094, 32'h8000_0400);
    hostWrite(12'h098, 32'h3333_4440);
    hostWrite(12'h09C, 32'h0000_0200);
    hostRead(12'h094, r); check(r == 32'h8000_0400, "R3 image byte count with load flag", {32'h0, r}, 64'h8000_0400);
    hostRead(12'h09C, r); check(r == 32'h0000_0200, "R3 data byte count", {32'h0, r}, 64'h200);
    check(!busy && writesSeen == 0, "R3 image writes start no copy", {63'h0, busy}, 64'h0);

    // R4 R5 basic copy
    setupCopy(32'h10, 32'h1000, 32'd5);
    hostRead(12'h004, r); check(r == 32'h10, "R3 source readback", {32'h0, r}, 64'h10);
    pushCopy(32'h10, 32'h1000, 5);
    hostWrite(12'h000, 32'h8000_0000);
    hostRead(12'h000, r); check(r[31], "R4 start bit reads 1 while copying", {32'h0, r}, 64'h8000_0000);
    waitIdle("R4 start bit clears at completion");
    hostRead(12'h010, r); check(r == 1, "R8 done after copy", {32'h0, r}, 64'h1);
    check(expQ.size() == 0, "R5 all words written", 64'(expQ.size()), 64'h0);

    // R5 backpressure
    setupCopy(32'h40, 32'h2000, 32'd4);
    pushCopy(32'h40, 32'h2000, 4);
    dstReady = 1'b0;
    hostWrite(12'h000, 32'h8000_0000);
    hostRead(12'h010, r); check(r == 0, "R8 done cleared by new start", {32'h0, r}, 64'h0);
    tick(3);
    check(dstWrEn && dstAddr == 32'h2000, "R5 stalled write held", {dstAddr, 31'h0, dstWrEn}, {32'h2000, 32'h1});
    for (int k = 0; k < 12; k++) begin dstReady = k[0]; tick(1); end
    dstReady = 1'b1;
    waitIdle("R5 stalled copy completes");
    check(expQ.size() == 0, "R5 stalled copy words", 64'(expQ.size()), 64'h0);

    // R6 wrap of the source index
    setupCopy(32'h3F8, 32'h3000, 32'd4);
    pushCopy(32'h3F8, 32'h3000, 4);
    hostWrite(12'h000, 32'h8000_0000);
    waitIdle("R6 wrap copy completes");
    check(expQ.size() == 0, "R6 wrapped words", 64'(expQ.size()), 64'h0);

    // R7 zero count
    setupCopy(32'h0, 32'h4000, 32'd0);
    base = writesSeen;
    hostWrite(12'h000, 32'h8000_0000);
    check(busy, "R7 zero count busy one cycle", {63'h0, busy}, 64'h1);
    tick(1);
    check(!busy && done, "R7 zero count done", {62'h0, busy, done}, 64'h1);
    check(writesSeen == base, "R7 zero count makes no write", 64'(writesSeen - base), 64'h0);

    // R9 start while busy ignored, register changes do not alter the copy
    setupCopy(32'h20, 32'h5000, 32'd6);
    pushCopy(32'h20, 32'h5000, 6);
    dstReady = 1'b0;
    hostWrite(12'h000, 32'h8000_0000);
    setupCopy(32'h100, 32'h6000, 32'd2);
    hostWrite(12'h000, 32'h8000_0000);
    dstReady = 1'b1;
    waitIdle("R9 original copy completes");
    tick(4);
    check(!busy && expQ.size() == 0, "R9 second start ignored", {31'h0, busy, 32'(expQ.size())}, 64'h0);

    // R10 armed power-up copies
    setupCopy(32'h80, 32'h7000, 32'd3);
    hostWrite(12'h000, 32'h4000_0000);
    hostRead(12'h000, r); check(r == 32'h4000_0000, "R10 arm bit readback", {32'h0, r}, 64'h4000_0000);
    for (int rep = 0; rep < 2; rep++) begin
      pushCopy(32'h80, 32'h7000, 3);
      pulsePowerUp();
      check(busy, "R10 power-up launches copy", {63'h0, busy}, 64'h1);
      waitIdle("R10 power-up copy completes");
      check(expQ.size() == 0, "R10 power-up copy words", 64'(expQ.size()), 64'h0);
    end
    hostWrite(12'h000, 32'h0);
    base = writesSeen;
    pulsePowerUp();
    tick(4);
    check(!busy && done && writesSeen == base, "R10 pulse ignored while not armed",
          64'(writesSeen - base), 64'h0);

    // R11 start and power-up in the same cycle
    setupCopy(32'hC0, 32'h8000, 32'd3);
    hostWrite(12'h000, 32'h4000_0000);
    pushCopy(32'hC0, 32'h8000, 3);
    base = writesSeen;
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 12'h000; regWrData = 32'hC000_0000; powerUp = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; powerUp = 1'b0;
    waitIdle("R11 collision copy completes");
    tick(6);
    check(!busy && done && writesSeen - base == 3 && expQ.size() == 0,
          "R11 exactly one copy", 64'(writesSeen - base), 64'h3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule